// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-clock static memory with a registered front end. On every rising clock edge it captures the address, the write data and all control inputs. It then performs at most one access per cycle on a parameterized internal array of multi-lane words. A burst is opened by either of two address strobes. One strobe belongs to a processor and the other to a cache controller. After the opening access, a 2-bit counter supplies the low address bits of each later access. The counter steps in linear or interleaved order.

Writes go through a lane decoder. A global write request covers every lane of the word. Otherwise a lane is written only when the byte-write enable and that lane's own select are both active. Read data is captured in an output register, so an access sampled on one edge shows its data on `dout` after the next edge. The bus is split into `din`, `dout` and a pad enable `dout_en`, which lets a pad ring build the shared bidirectional bus. The pad enable follows the registered read path and the asynchronous output-enable pin. After a deselect it stays on for two more cycles.

Top module: `sbs_top`

## Requirements
- R1: An access whose inputs are sampled on edge N presents its read data on `dout` after edge N+1, so the data is valid during the cycle that starts at that edge.
- R2: A strobe cycle with the chip selected loads the full `adr`, clears the burst counter and opens a burst. This applies also in the middle of a running burst. If both strobes are low, `cpu_strb_n` wins, and any access opened by `cpu_strb_n` is a read whatever the write controls say.
- R3: In a cycle with no strobe inside an open burst, `step_n` low advances the counter by one before the access. With `step_n` high the counter holds, so the same address is accessed again.
- R4: With `order_ilv` = 0 sampled at the strobe, the low two address bits of access k are (start + k) mod 4. The upper bits keep the loaded value.
- R5: With `order_ilv` = 1 sampled at the strobe, the low two address bits of access k are start XOR k.
- R6: `all_wr_n` low writes every lane of the addressed word from `din`, whatever `bytes_wr_n` and `lane_wr_n` are.
- R7: When `all_wr_n` is high, lane i (bits 8i+7..8i) is written only when `bytes_wr_n` and `lane_wr_n[i]` are both low. A cycle with no lane selected is a read.
- R8: The chip is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 in a strobe cycle. A strobe with any of them inactive closes the burst, and no access happens until the next selected strobe.
- R9: After the edge that samples a deselect, `dout_en` stays high with the last read data for two cycles and then goes low.
- R10: `out_en_n` high forces `dout_en` low at once, without waiting for a clock edge.
- R11: After reset no burst is open and `dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the control pipeline |
| adr | input | ADDR_W | Word address, loaded when a burst opens |
| cpu_strb_n | input | 1 | Processor address strobe, active low, read only |
| ctl_strb_n | input | 1 | Cache-controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Global write of all lanes, active low |
| bytes_wr_n | input | 1 | Byte-write enable, active low |
| lane_wr_n | input | LANES | Per-lane write selects, active low |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*LANE_W | Write data from the bus |
| dout | output | LANES*LANE_W | Registered read data |
| dout_en | output | 1 | Pad driver enable for `dout` |

## Verification
The bench compares the data from each access with a reference array, so a counter that steps on the wrong cycle, or a read path with one register too many or too few, produces the wrong word. Four-beat bursts from low start bits 2 and 3 catch a linear counter that carries into bit 2 and an interleaved order that is built as addition. The bench pulses both strobes together with the write controls active, and it issues strobes while each chip select in turn is inactive. A design that lets the cache-strobe decode win, or that gates only one select, would then corrupt stored words. A lane-by-lane pattern separates correct byte masking from global-write override. Edge counting after a deselect exposes a driver that releases the bus one cycle early or late.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
package sbs_pkg;
   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_RD   = 2'd1,
      OP_WR   = 2'd2
   } sbs_op_e;

   // low two address bits for beat cnt of a burst that started at start
   function automatic logic [1:0] beat_low(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input logic       ilv);
      return ilv ? (start ^ cnt) : (start + cnt);
   endfunction
endpackage

// File: rtl/sbs_burst_seq.sv
`timescale 1ns/1ps
module sbs_burst_seq #(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              close,
   input  logic              step,
   input  logic              ilv_in,
   input  logic [ADDR_W-1:0] adr,
   output logic              open_q,
   output logic [1:0]        cnt_q,
   output logic [ADDR_W-1:0] base_q,
   output logic [ADDR_W-1:0] eff_addr
);
   import sbs_pkg::*;

   logic ilv_q;

   generate
      if (ADDR_W < 2) begin : g_bad_w
         $error("sbs_burst_seq: ADDR_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         cnt_q  <= 2'd0;
         base_q <= '0;
         ilv_q  <= 1'b0;
      end else if (load) begin
         open_q <= 1'b1;
         cnt_q  <= 2'd0;
         base_q <= adr;
         ilv_q  <= ilv_in;
      end else if (close) begin
         open_q <= 1'b0;
      end else if (open_q && step) begin
         cnt_q <= cnt_q + 2'd1;
      end
   end

   logic [1:0] low_bits;
   assign low_bits = beat_low(base_q[1:0], cnt_q, ilv_q);

   generate
      if (ADDR_W == 2) begin : g_narrow
         assign eff_addr = low_bits;
      end else begin : g_wide
         assign eff_addr = {base_q[ADDR_W-1:2], low_bits};
      end
   endgenerate
endmodule

// File: rtl/sbs_lane_dec.sv
`timescale 1ns/1ps
module sbs_lane_dec #(
   parameter int LANES = 4
) (
   input  logic             all_wr_n,
   input  logic             bytes_wr_n,
   input  logic [LANES-1:0] lane_wr_n,
   output logic [LANES-1:0] lane_mask
);
   generate
      if (LANES < 1) begin : g_bad_l
         $error("sbs_lane_dec: LANES must be at least 1");
      end
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign lane_mask[i] = !all_wr_n || (!bytes_wr_n && !lane_wr_n[i]);
      end
   endgenerate
endmodule

// File: rtl/sbs_lane_ram.sv
`timescale 1ns/1ps
module sbs_lane_ram #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rd,
   input  logic [LANES-1:0]        we,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (LANE_W < 1) begin : g_bad_lw
         $error("sbs_lane_ram: LANE_W must be at least 1");
      end
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         logic [LANE_W-1:0] mem [DEPTH];
         always_ff @(posedge clk) begin
            if (we[i]) mem[addr] <= wdata[i*LANE_W +: LANE_W];
            if (rd)    rdata[i*LANE_W +: LANE_W] <= mem[addr];
         end
      end
   endgenerate
endmodule

// File: rtl/sbs_out_hold.sv
`timescale 1ns/1ps
module sbs_out_hold #(
   parameter int HOLD_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_fire,
   input  logic wr_fire,
   output logic live
);
   localparam int CW = $clog2(HOLD_CYC + 1);

   logic [CW-1:0] left_q;

   generate
      if (HOLD_CYC < 1) begin : g_bad_h
         $error("sbs_out_hold: HOLD_CYC must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)              left_q <= '0;
      else if (rd_fire)        left_q <= CW'(HOLD_CYC);
      else if (wr_fire)        left_q <= '0;
      else if (left_q != '0)   left_q <= left_q - 1'b1;
   end

   assign live = (left_q != '0);
endmodule

// File: rtl/sbs_top.sv
`timescale 1ns/1ps
module sbs_top #(
   parameter int ADDR_W   = 6,
   parameter int LANES    = 4,
   parameter int LANE_W   = 8,
   parameter int HOLD_CYC = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       adr,
   input  logic                    cpu_strb_n,
   input  logic                    ctl_strb_n,
   input  logic                    step_n,
   input  logic                    all_wr_n,
   input  logic                    bytes_wr_n,
   input  logic [LANES-1:0]        lane_wr_n,
   input  logic                    sel_a_n,
   input  logic                    sel_b,
   input  logic                    sel_c_n,
   input  logic                    order_ilv,
   input  logic                    out_en_n,
   input  logic [LANES*LANE_W-1:0] din,
   output logic [LANES*LANE_W-1:0] dout,
   output logic                    dout_en
);
   import sbs_pkg::*;

   localparam int DW = LANES * LANE_W;

   logic              chip_sel, any_strb, load, close, cont, wr_req;
   logic [LANES-1:0]  lane_mask;
   sbs_op_e           op_d, op_q;
   logic [LANES-1:0]  lanes_q;
   logic [DW-1:0]     din_q;
   logic              open_q;
   logic [1:0]        cnt_q;
   logic [ADDR_W-1:0] base_q, eff_addr;
   logic              live;

   assign chip_sel = !sel_a_n && sel_b && !sel_c_n;
   assign any_strb = !cpu_strb_n || !ctl_strb_n;
   assign load     = any_strb && chip_sel;
   assign close    = any_strb && !chip_sel;
   assign cont     = !any_strb && open_q;

   sbs_lane_dec #(.LANES(LANES)) u_dec (
      .all_wr_n  (all_wr_n),
      .bytes_wr_n(bytes_wr_n),
      .lane_wr_n (lane_wr_n),
      .lane_mask (lane_mask)
   );

   assign wr_req = |lane_mask;

   always_comb begin
      op_d = OP_NONE;
      if (load)      op_d = (!cpu_strb_n || !wr_req) ? OP_RD : OP_WR;
      else if (cont) op_d = wr_req ? OP_WR : OP_RD;
   end

   sbs_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .close   (close),
      .step    (cont && !step_n),
      .ilv_in  (order_ilv),
      .adr     (adr),
      .open_q  (open_q),
      .cnt_q   (cnt_q),
      .base_q  (base_q),
      .eff_addr(eff_addr)
   );

   // input register stage for the access itself
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q    <= OP_NONE;
         lanes_q <= '0;
      end else begin
         op_q    <= op_d;
         lanes_q <= (op_d == OP_WR) ? lane_mask : '0;
      end
      din_q <= din;
   end

   sbs_lane_ram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_ram (
      .clk  (clk),
      .rd   (op_q == OP_RD),
      .we   ((op_q == OP_WR) ? lanes_q : '0),
      .addr (eff_addr),
      .wdata(din_q),
      .rdata(dout)
   );

   sbs_out_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_fire(op_q == OP_RD),
      .wr_fire(op_q == OP_WR),
      .live   (live)
   );

   assign dout_en = live && !out_en_n;
endmodule

// File: rtl/sbs_chk.sv
`timescale 1ns/1ps
module sbs_chk #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] adr,
   input logic              cpu_strb_n,
   input logic              ctl_strb_n,
   input logic              step_n,
   input logic              all_wr_n,
   input logic              sel_a_n,
   input logic              sel_b,
   input logic              sel_c_n,
   input logic              out_en_n,
   input logic              dout_en,
   input logic              open_q,
   input logic [1:0]        cnt_q,
   input logic [ADDR_W-1:0] base_q,
   input sbs_pkg::sbs_op_e  op_q,
   input logic [LANES-1:0]  lanes_q,
   input logic              live
);
   import sbs_pkg::*;

   logic sel_ok, strb;
   assign sel_ok = !sel_a_n && sel_b && !sel_c_n;
   assign strb   = !cpu_strb_n || !ctl_strb_n;

   // R2
   load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strb && sel_ok) |=> (cnt_q == 2'd0 && base_q == $past(adr) && open_q));

   // R2
   cpu_strobe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_strb_n && sel_ok) |=> (op_q == OP_RD));

   // R3
   step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!strb && open_q && !step_n) |=> (cnt_q == $past(cnt_q) + 2'd1));

   // R3
   hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!strb && step_n) |=> $stable(cnt_q));

   // R6
   global_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!all_wr_n && cpu_strb_n && ((!ctl_strb_n && sel_ok) || (!strb && open_q)))
      |=> (op_q == OP_WR && lanes_q == '1));

   // R8
   deselect_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strb && !sel_ok) |=> (!open_q && op_q == OP_NONE));

   // R9
   release_after_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_q) == OP_NONE && $past(op_q, 2) == OP_NONE) |-> !live);

   // R10
   oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dout_en |-> !out_en_n);
endmodule

bind sbs_top sbs_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .adr       (adr),
   .cpu_strb_n(cpu_strb_n),
   .ctl_strb_n(ctl_strb_n),
   .step_n    (step_n),
   .all_wr_n  (all_wr_n),
   .sel_a_n   (sel_a_n),
   .sel_b     (sel_b),
   .sel_c_n   (sel_c_n),
   .out_en_n  (out_en_n),
   .dout_en   (dout_en),
   .open_q    (open_q),
   .cnt_q     (cnt_q),
   .base_q    (base_q),
   .op_q      (op_q),
   .lanes_q   (lanes_q),
   .live      (live)
);

// File: tb/tb_sbs_top.sv
`timescale 1ns/1ps
module tb_sbs_top;
   localparam int AW = 6;
   localparam int NL = 4;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] adr;
   logic          cpu_strb_n, ctl_strb_n, step_n, all_wr_n, bytes_wr_n;
   logic [NL-1:0] lane_wr_n;
   logic          sel_a_n, sel_b, sel_c_n, order_ilv, out_en_n;
   logic [DW-1:0] din, dout;
   logic          dout_en;

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] ref_mem [1 << AW];

   sbs_top dut (
      .clk(clk), .rst_n(rst_n), .adr(adr), .cpu_strb_n(cpu_strb_n),
      .ctl_strb_n(ctl_strb_n), .step_n(step_n), .all_wr_n(all_wr_n),
      .bytes_wr_n(bytes_wr_n), .lane_wr_n(lane_wr_n), .sel_a_n(sel_a_n),
      .sel_b(sel_b), .sel_c_n(sel_c_n), .order_ilv(order_ilv),
      .out_en_n(out_en_n), .din(din), .dout(dout), .dout_en(dout_en)
   );

   always #2 clk = ~clk;

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] beat(input logic [AW-1:0] b, input bit ilv,
                                          input logic [1:0] k);
      return {b[AW-1:2], ilv ? (b[1:0] ^ k) : (b[1:0] + k)};
   endfunction

   // quiet inputs: no strobe, no step, no write, selected, bus enabled
   task automatic idle();
      cpu_strb_n = 1; ctl_strb_n = 1; step_n = 1; all_wr_n = 1;
      bytes_wr_n = 1; lane_wr_n = '1; sel_a_n = 0; sel_b = 1; sel_c_n = 0;
      out_en_n = 0;
   endtask

   task automatic deselect();
      idle(); cpu_strb_n = 0; sel_b = 0;
      @(negedge clk); idle();
      @(negedge clk); @(negedge clk);
   endtask

   // four-beat global-write burst through the cache strobe
   task automatic wr_burst(input logic [AW-1:0] b, input bit ilv, input logic [DW-1:0] seed);
      for (int i = 0; i < 4; i++) begin
         idle(); out_en_n = 1; all_wr_n = 0;
         if (i == 0) begin ctl_strb_n = 0; adr = b; order_ilv = ilv; end
         else step_n = 0;
         din = seed + DW'(i * 32'h01010101);
         ref_mem[beat(b, ilv, 2'(i))] = din;
         @(negedge clk);
      end
      idle(); out_en_n = 1;
      @(negedge clk);
      deselect();
   endtask

   // kinds: 0 strobe new base, 1 step, 2 hold
   task automatic rd_seq(input logic [AW-1:0] bases[6], input int kinds[6], input int n,
                         input bit ilv, input string req);
      logic [DW-1:0] exp [6];
      logic [AW-1:0] cb;
      logic [1:0]    k;
      cb = '0; k = '0;
      for (int j = 0; j < n + 2; j++) begin
         if (j >= 2) chk(dout_en && dout == exp[j-2], req, dout, exp[j-2]);
         idle();
         if (j < n) begin
            if (kinds[j] == 0) begin
               cpu_strb_n = 0; adr = bases[j]; order_ilv = ilv; cb = bases[j]; k = 0;
            end else if (kinds[j] == 1) begin
               step_n = 0; k = k + 2'd1;
            end
            exp[j] = ref_mem[beat(cb, ilv, k)];
         end
         @(negedge clk);
      end
      deselect();
   endtask

   task automatic t_reset();
      idle(); rst_n = 0; adr = '0; din = '0; order_ilv = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk); @(negedge clk);
      chk(!dout_en, "R11 bus off after reset", {31'd0, dout_en}, '0);
      // write controls with no open burst must not touch the array
      idle(); all_wr_n = 0; out_en_n = 1; din = 32'hBAD0BAD0;
      @(negedge clk); idle(); @(negedge clk);
      chk(!dout_en, "R11 no burst open after reset", {31'd0, dout_en}, '0);
   endtask

   task automatic t_linear();
      logic [AW-1:0] b[6]; int kd[6];
      wr_burst(6'h0A, 0, 32'h11223344);   // start 2 linear: A,B,8,9
      b = '{6'h0A, 0, 0, 0, 0, 0}; kd = '{0, 1, 1, 1, 2, 2};
      rd_seq(b, kd, 4, 0, "R4 linear wrap R1");
   endtask

   task automatic t_interleave();
      logic [AW-1:0] b[6]; int kd[6];
      wr_burst(6'h13, 1, 32'hA0B0C0D0);   // start 3 interleaved: 13,12,11,10
      b = '{6'h13, 0, 0, 0, 0, 0}; kd = '{0, 1, 1, 1, 2, 2};
      rd_seq(b, kd, 4, 1, "R5 interleaved order");
      b = '{6'h11, 0, 0, 0, 0, 0};
      rd_seq(b, kd, 4, 1, "R5 interleaved from 1");
   endtask

   task automatic t_hold_restart();
      logic [AW-1:0] b[6]; int kd[6];
      b = '{6'h08, 0, 0, 6'h12, 0, 0}; kd = '{0, 2, 1, 0, 1, 2};
      rd_seq(b, kd, 6, 0, "R3 hold and R2 restart");
   endtask

   task automatic t_lanes();
      logic [AW-1:0] b[6]; int kd[6];
      // byte write: lanes 0 and 2 only (lane i = bits 8i+7..8i)
      idle(); out_en_n = 1; ctl_strb_n = 0; adr = 6'h0A; bytes_wr_n = 0;
      lane_wr_n = 4'b1010; din = 32'hCAFEF00D;
      ref_mem[6'h0A] = {ref_mem[6'h0A][31:24], 8'hFE, ref_mem[6'h0A][15:8], 8'h0D};
      @(negedge clk);
      // lanes selected but byte-write enable off: a read, nothing written
      idle(); out_en_n = 1; lane_wr_n = 4'b0000; din = 32'h0;
      @(negedge clk);
      deselect();
      // global write overrides inactive byte controls
      idle(); out_en_n = 1; ctl_strb_n = 0; adr = 6'h0B; all_wr_n = 0;
      din = 32'h5A5A1234; ref_mem[6'h0B] = din;
      @(negedge clk);
      idle(); out_en_n = 1; @(negedge clk);
      deselect();
      b = '{6'h0A, 0, 0, 0, 0, 0}; kd = '{0, 1, 2, 2, 2, 2};
      rd_seq(b, kd, 2, 0, "R7 byte lanes R6 global");
   endtask

   task automatic t_priority();
      logic [AW-1:0] b[6]; int kd[6];
      idle(); cpu_strb_n = 0; ctl_strb_n = 0; all_wr_n = 0; adr = 6'h08;
      order_ilv = 0; out_en_n = 0; din = 32'hDEADBEEF;
      @(negedge clk); idle(); @(negedge clk);
      chk(dout_en && dout == ref_mem[6'h08], "R2 cpu strobe read priority",
          dout, ref_mem[6'h08]);
      deselect();
      b = '{6'h08, 0, 0, 0, 0, 0}; kd = '{0, 2, 2, 2, 2, 2};
      rd_seq(b, kd, 1, 0, "R2 no write on dual strobe");
   endtask

   task automatic t_selects();
      logic [AW-1:0] b[6]; int kd[6];
      for (int s = 0; s < 3; s++) begin
         idle(); out_en_n = 1; ctl_strb_n = 0; adr = 6'h09; all_wr_n = 0;
         din = 32'h0BADF00D;
         if (s == 0) sel_a_n = 1; else if (s == 1) sel_b = 0; else sel_c_n = 1;
         @(negedge clk);
         // still no burst: later write cycles must do nothing
         idle(); out_en_n = 1; all_wr_n = 0; step_n = 0;
         @(negedge clk); idle(); @(negedge clk);
      end
      b = '{6'h09, 0, 0, 0, 0, 0}; kd = '{0, 2, 2, 2, 2, 2};
      rd_seq(b, kd, 1, 0, "R8 chip selects");
   endtask

   task automatic t_deselect_timing();
      idle(); cpu_strb_n = 0; adr = 6'h12; order_ilv = 0;
      @(negedge clk); idle(); @(negedge clk); @(negedge clk);
      // deselect sampled on the next edge
      idle(); cpu_strb_n = 0; sel_c_n = 1;
      @(negedge clk); idle();
      chk(dout_en, "R9 driven cycle 1", {31'd0, dout_en}, 1);
      @(negedge clk);
      chk(dout_en && dout == ref_mem[6'h12], "R9 driven cycle 2 data", dout, ref_mem[6'h12]);
      @(negedge clk);
      chk(!dout_en, "R9 released after two", {31'd0, dout_en}, 0);
   endtask

   task automatic t_oe();
      idle(); cpu_strb_n = 0; adr = 6'h13;
      @(negedge clk); idle(); @(negedge clk);
      chk(dout_en, "R10 enabled read", {31'd0, dout_en}, 1);
      out_en_n = 1; #1;
      chk(!dout_en, "R10 out_en_n high releases at once", {31'd0, dout_en}, 0);
      @(negedge clk); out_en_n = 0; #1;
      chk(dout_en && dout == ref_mem[6'h13], "R10 re-enabled data", dout, ref_mem[6'h13]);
      deselect();
   endtask

   initial begin
      #(4 * 100000);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", checks);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_linear();
      t_interleave();
      t_hold_restart();
      t_lanes();
      t_priority();
      t_selects();
      t_deselect_timing();
      t_oe();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule